// File: doc/BRIEF.md
# Circuit-Switched Stream Fan-Out Port

This block is one input port of a stream crossbar running in circuit-switched mode. A single 32-bit source stream with valid/ready handshaking and an end-of-frame flag enters the port. Each beat is copied to every output named in a programmable destination bitmask. All selected outputs see the same data and end flag together. A beat leaves the port only when every selected output takes it in the same cycle. Backpressure from any one selected output therefore stalls the whole stream.

A small input buffer sits in front of an output register. This gives a fixed latency of two clock cycles and sustains one word per cycle when nothing stalls. A register write port loads the destination mask and a mode bit. When the mode bit is set, the port is handed over to packet switching, and the circuit-switched fan-out is switched off. A write is held as pending until the port has drained, so the route and mode never change under a beat in flight.

Top module: `stream_fanout_port`

## Requirements
- R1: Every accepted beat appears on the outputs with its data and end flag unchanged, in acceptance order, exactly once.
- R2: A beat is removed only in a cycle where every output in the destination mask has ready high. Output `m_valid[i]` is high only when bit i of the mask is set, and all selected outputs assert valid together.
- R3: While a presented beat is not removed, `m_valid`, `m_data` and `m_last` hold their values.
- R4: Consider an idle port whose outputs are all ready. A beat accepted at clock edge N is presented after edge N+1. Back-to-back beats are accepted at one per cycle.
- R5: When all selected outputs are stalled, the port holds at most DEPTH+1 beats: DEPTH in the buffer plus one in the output register. With DEPTH=4, `s_ready` drops after five beats have been accepted.
- R6: With an all-zero destination mask in circuit mode, beats are accepted with `s_ready` high and discarded. No `m_valid` bit rises.
- R7: With the mode bit (`cfg_pkt`) set to 1, `s_ready` is low and every `m_valid` bit is low. With the mode bit at 0, the port runs the circuit-switched fan-out.
- R8: A configuration write is held pending until the buffer and the output register are both empty, and then takes effect. While the write is pending, `s_ready` is low and beats already inside the port keep the old mask.
- R9: After reset, the mask is zero and the mode bit selects circuit mode. The port is empty, `s_ready` is high and all `m_valid` bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dest | input | NDST | Destination bitmask to load |
| cfg_pkt | input | 1 | Mode bit to load: 0 = circuit, 1 = packet |
| s_valid | input | 1 | Source beat valid |
| s_ready | output | 1 | Port can accept a beat |
| s_data | input | DW | Source beat data |
| s_last | input | 1 | Source end-of-frame flag |
| m_valid | output | NDST | Per-destination valid |
| m_ready | input | NDST | Per-destination ready |
| m_data | output | DW | Data shared by all destinations |
| m_last | output | 1 | End-of-frame flag shared by all destinations |

## Verification
The hardest situation to reach from the ports is a configuration write that arrives while beats are still stored inside the port. In that state, the old mask must keep steering the queued beats while the source is blocked. The bench gets there by stalling every destination and pushing beats into the buffer, then issuing the write. It then releases the destinations and watches the old route drain before the new mask appears. A second hard case is a stall where only some selected outputs are ready. A ready pattern taken from a shift register reaches that case many times during a long random run, and a directed step with a single ready output covers it once more.

// File: rtl/stream_fanout_port.sv
`timescale 1ns/1ps
module stream_fanout_port #(
  parameter int DW    = 32,
  parameter int NDST  = 4,
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [NDST-1:0] cfg_dest,
  input  logic            cfg_pkt,
  input  logic            s_valid,
  output logic            s_ready,
  input  logic [DW-1:0]   s_data,
  input  logic            s_last,
  output logic [NDST-1:0] m_valid,
  input  logic [NDST-1:0] m_ready,
  output logic [DW-1:0]   m_data,
  output logic            m_last
);

  logic [NDST-1:0] mask, pend_mask;
  logic            pkt, pend_pkt, pend_v;
  logic [DW:0]     mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [CW-1:0]   cnt;
  logic            out_v, out_l;
  logic [DW-1:0]   out_d;
  logic            idle, fire, push, load;

  assign idle    = (cnt == '0) && !out_v;
  assign s_ready = !pkt && !pend_v && (cnt != CW'(DEPTH));
  assign fire    = out_v && ((m_ready & mask) == mask);
  assign push    = s_valid && s_ready;
  assign load    = (cnt != '0) && (!out_v || fire);
  assign m_valid = {NDST{out_v}} & mask;
  assign m_data  = out_d;
  assign m_last  = out_l;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask      <= '0;
      pkt       <= 1'b0;
      pend_v    <= 1'b0;
      pend_mask <= '0;
      pend_pkt  <= 1'b0;
    end else if (cfg_we) begin
      pend_v    <= 1'b1;
      pend_mask <= cfg_dest;
      pend_pkt  <= cfg_pkt;
    end else if (pend_v && idle) begin
      pend_v <= 1'b0;
      mask   <= pend_mask;
      pkt    <= pend_pkt;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {s_last, s_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (load) rp <= rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(load);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v <= 1'b0;
      out_d <= '0;
      out_l <= 1'b0;
    end else if (load) begin
      out_v <= 1'b1;
      {out_l, out_d} <= mem[rp];
    end else if (fire) begin
      out_v <= 1'b0;
    end
  end

endmodule

// File: rtl/fanout_port_chk.sv
`timescale 1ns/1ps
module fanout_port_chk #(
  parameter int DW    = 32,
  parameter int NDST  = 4,
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            s_ready,
  input logic [NDST-1:0] m_valid,
  input logic [NDST-1:0] m_ready,
  input logic [DW-1:0]   m_data,
  input logic            m_last,
  input logic [NDST-1:0] mask,
  input logic            pkt,
  input logic            pend_v,
  input logic [CW-1:0]   cnt,
  input logic            out_v
);

  logic stall;
  assign stall = (m_valid != '0) && ((m_ready & m_valid) != m_valid);

  a_r3_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(m_data) && $stable(m_last) && $stable(m_valid));

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  a_r6_empty_mask_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) && !pkt && !pend_v |-> s_ready && (m_valid == '0));

  a_r7_packet_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pkt |-> !s_ready && (m_valid == '0));

  a_r8_cfg_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mask) || !$stable(pkt) |-> $past((cnt == '0) && !out_v));

endmodule

bind stream_fanout_port fanout_port_chk #(.DW(DW), .NDST(NDST), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .m_valid(m_valid),
  .m_ready(m_ready), .m_data(m_data), .m_last(m_last), .mask(mask),
  .pkt(pkt), .pend_v(pend_v), .cnt(cnt), .out_v(out_v)
);

// File: tb/sim_stream_fanout_port.sv
`timescale 1ns/1ps
module sim_stream_fanout_port;
  localparam int DW = 32, NDST = 4;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_pkt = 0;
  logic [NDST-1:0] cfg_dest = '0, m_ready = '0, m_valid;
  logic s_valid = 0, s_last = 0, s_ready, m_last;
  logic [DW-1:0] s_data = '0, m_data;

  int checks = 0, fails = 0, cyc = 0;
  logic [NDST-1:0] em = '0;
  logic [DW:0] q[$];
  logic rnd_en = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  stream_fanout_port #(.DW(DW), .NDST(NDST), .DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dest(cfg_dest), .cfg_pkt(cfg_pkt),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rnd_en) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_ready = lfsr[3:0];
  end

  // monitor: pops expected beats when every selected output takes one
  always begin
    @(negedge clk); #2;
    if (rst_n && m_valid != '0) begin
      chk(m_valid == em, "R2 valid pattern", 64'(m_valid), 64'(em));
      if ((m_ready & em) == em && m_valid == em) begin
        if (q.size() == 0) chk(0, "R1 unexpected beat", 64'({m_last, m_data}), 0);
        else begin
          logic [DW:0] e;
          e = q.pop_front();
          chk({m_last, m_data} == e, "R1 beat content", 64'({m_last, m_data}), 64'(e));
        end
      end
    end
  end

  task automatic send(input logic [DW-1:0] d, input logic l);
    s_valid = 1; s_data = d; s_last = l;
    #2;
    while (!s_ready) begin @(negedge clk); #2; end
    if (em != '0) q.push_back({l, d});
    @(negedge clk);
    s_valid = 0;
  endtask

  task automatic cfg(input logic [NDST-1:0] d, input logic p);
    cfg_we = 1; cfg_dest = d; cfg_pkt = p;
    @(negedge clk); cfg_we = 0;
    @(negedge clk); @(negedge clk);
    em = p ? '0 : d;
  endtask

  task automatic drain(input string req);
    repeat (12) @(negedge clk);
    chk(q.size() == 0, req, 64'(q.size()), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    chk(s_ready == 1, "R9 ready after reset", 64'(s_ready), 1);
    chk(m_valid == '0, "R9 valid low after reset", 64'(m_valid), 0);
    @(negedge clk);

    // R4 latency
    m_ready = 4'b1111;
    cfg(4'b1111, 0);
    s_valid = 1; s_data = 32'hA5A5_0001; s_last = 1;
    #2; chk(s_ready == 1, "R4 accept", 64'(s_ready), 1);
    q.push_back({1'b1, 32'hA5A5_0001});
    @(negedge clk); s_valid = 0;
    #2; chk(m_valid == '0, "R4 not yet presented", 64'(m_valid), 0);
    @(negedge clk);
    #2; chk(m_valid == 4'b1111, "R4 presented after two edges", 64'(m_valid), 64'hF);
    @(negedge clk);

    // R4 throughput
    begin
      int t0;
      t0 = cyc;
      for (int k = 0; k < 8; k++) send(32'h100 + k, k == 7);
      chk(cyc - t0 == 8, "R4 one beat per cycle", 64'(cyc - t0), 8);
    end
    drain("R1 throughput drain");

    // R5 buffer bound, R3 hold, R2 partial ready
    cfg(4'b0011, 0);
    m_ready = '0;
    begin
      int acc;
      acc = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk); s_valid = 1; s_data = 32'h200 + k; s_last = 0;
        #2; if (s_ready) begin q.push_back({1'b0, 32'h200 + k}); acc++; end
      end
      @(negedge clk); s_valid = 0;
      chk(acc == 5, "R5 beats held while stalled", 64'(acc), 5);
    end
    begin
      logic [DW-1:0] d0;
      #2; d0 = m_data;
      @(negedge clk); m_ready = 4'b0001;
      repeat (2) @(negedge clk);
      #2;
      chk(m_data == d0, "R3 data held under partial ready", 64'(m_data), 64'(d0));
      chk(m_valid == 4'b0011, "R2 no pop with one selected ready", 64'(m_valid), 3);
    end
    @(negedge clk); m_ready = 4'b1011;
    drain("R1 drain after stall");
    m_ready = 4'b1111;

    // R6 empty mask
    cfg(4'b0000, 0);
    m_ready = '0;
    for (int k = 0; k < 3; k++) begin
      s_valid = 1; s_data = 32'h300 + k;
      #2; chk(s_ready == 1, "R6 ready with empty mask", 64'(s_ready), 1);
      @(negedge clk);
    end
    s_valid = 0;
    for (int k = 0; k < 4; k++) begin
      #2; chk(m_valid == '0, "R6 no output with empty mask", 64'(m_valid), 0);
      @(negedge clk);
    end

    // R7 packet mode
    m_ready = 4'b1111;
    cfg(4'b1111, 1);
    s_valid = 1; s_data = 32'h400;
    for (int k = 0; k < 3; k++) begin
      #2;
      chk(s_ready == 0, "R7 not ready in packet mode", 64'(s_ready), 0);
      chk(m_valid == '0, "R7 no valid in packet mode", 64'(m_valid), 0);
      @(negedge clk);
    end
    s_valid = 0;
    cfg(4'b1111, 0);
    send(32'h401, 1);
    drain("R7 circuit mode restored");

    // R8 pending configuration
    cfg(4'b0001, 0);
    m_ready = '0;
    send(32'h500, 0);
    send(32'h501, 1);
    cfg_we = 1; cfg_dest = 4'b0110; cfg_pkt = 0;
    @(negedge clk); cfg_we = 0;
    #2;
    chk(s_ready == 0, "R8 blocked while pending", 64'(s_ready), 0);
    chk(m_valid == 4'b0001, "R8 old mask kept", 64'(m_valid), 1);
    @(negedge clk); m_ready = 4'b1111;
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R8 old beats drained", 64'(q.size()), 0);
    em = 4'b0110;
    #2; chk(s_ready == 1, "R8 ready after apply", 64'(s_ready), 1);
    @(negedge clk);
    send(32'h502, 1);
    #2; @(negedge clk); #2;
    chk(m_valid == 4'b0110, "R8 new mask in effect", 64'(m_valid), 6);
    drain("R8 new route drain");

    // R1 random backpressure
    cfg(4'b1011, 0);
    rnd_en = 1;
    for (int k = 0; k < 40; k++) send(32'hC000 + k * 7, (k % 5) == 4);
    @(negedge clk); rnd_en = 0; m_ready = 4'b1111;
    drain("R1 random drain");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule